// File: doc/BRIEF.md
# Serial-Bus Byte DMA Channel

This block is a single DMA channel that serves the data register of a byte-oriented serial bus controller. Software loads a peripheral address, a memory address, a byte count and a control word through a small register port. The channel then moves one byte for each request, either from a simple memory port into the controller's data register (transmit) or from the data register into memory (receive).

The controller's buffer flags pace the requests. In transmit mode the transmit-buffer-empty flag starts a byte. In receive mode the receive-buffer-full flag starts a byte. The controller's DMA-enable bit and the channel's enable bit must both be set. When the count reaches zero, the channel raises a completion flag and, if enabled, an interrupt. In receive mode it can also pulse an automatic-NACK line so the controller refuses the next byte. While DMA mode is active, the controller's per-byte data-buffer interrupt is masked.

Register port map, selected by `cfg_addr`:
- 0: peripheral address.
- 1: memory address. Reads return the current value.
- 2: byte count. Reads return the remaining count.
- 3: control. Bit 0 is the channel enable. Bit 1 is the direction. Bit 2 is the interrupt enable. Bit 3 is the completion flag and reads only.

Top module: `sbus_dma_chan`

## Requirements
- R1: Control bit 1 = 1 moves bytes from memory (`mem_re`) to the data register (`dr_wr`). Control bit 1 = 0 reads the data register (`dr_rd`) and writes memory (`mem_we`).
- R2: Each request moves exactly one byte. At most one of `mem_re`, `mem_we`, `dr_wr`, `dr_rd` is high in any cycle. A flag that stays set is not serviced twice.
- R3: The count at address 2 decreases by one per byte moved. No byte is moved while it is zero. `remain_cnt` and a read of address 2 show the remaining value.
- R4: The memory address increases by one after each byte. `per_addr` holds the programmed peripheral address unchanged.
- R5: In the cycle `remain_cnt` first shows zero, the completion flag (control bit 3) sets, and `irq` goes high if control bit 2 is set. Both stay set until software writes address 2 or 3. A completion in the same cycle as such a write wins.
- R6: Bytes move only while control bit 0 and `dma_en` are both 1. Clearing bit 0 lets a byte already in flight finish, starts no further byte, and leaves the remaining count readable.
- R7: A transmit byte starts only when `txe` = 1. A receive byte starts only when `rxne` = 1. The data-register write or read is the event that lets the controller drop that flag.
- R8: `auto_nack` pulses for one cycle, in the cycle `remain_cnt` shows zero, only when all of these hold: the direction is receive, `eod_en` = 1, and the count last written was at least 2.
- R9: `buf_irq_out` is `buf_irq_en` AND NOT `dma_en`, registered one cycle.
- R10: After reset, every output is 0 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Registered read data for `cfg_addr` |
| dma_en | input | 1 | Controller DMA-enable bit |
| eod_en | input | 1 | Controller end-of-DMA NACK option bit |
| txe | input | 1 | Controller transmit buffer empty |
| rxne | input | 1 | Controller receive buffer full |
| buf_irq_en | input | 1 | Software per-byte data-buffer interrupt enable |
| buf_irq_out | output | 1 | Effective data-buffer interrupt enable |
| per_addr | output | AW | Peripheral (data register) address |
| dr_wr | output | 1 | Data register write strobe |
| dr_wdata | output | DW | Data register write byte |
| dr_rd | output | 1 | Data register read strobe |
| dr_rdata | input | DW | Data register contents |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_rdata | input | DW | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write byte |
| remain_cnt | output | CW | Remaining byte count |
| irq | output | 1 | Completion interrupt |
| auto_nack | output | 1 | One-cycle NACK request after the last received byte |

## Verification
The commit of the final byte and a software write to the control register can fall in the same clock edge: one sets the completion flag, the other clears it and drops the channel enable. The bench waits until the data-register write strobe of a one-byte transmit is visible and raises the control write in that same cycle. It then judges that `irq` is high in the next cycle with a zero count and exactly one byte sent, and that a later control write clears it. A second overlap sends a channel-enable clear just after a middle byte commits while the flag is refilling. This must leave the count and memory address frozen at their mid-run values.

// File: rtl/sbdma_pkg.sv
package sbdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_RD,
    ST_TX_WAIT,
    ST_RX_RD,
    ST_COMMIT
  } xfer_state_t;

  localparam logic [1:0] RA_PADDR = 2'd0;
  localparam logic [1:0] RA_MADDR = 2'd1;
  localparam logic [1:0] RA_COUNT = 2'd2;
  localparam logic [1:0] RA_CTRL  = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_DONE = 3;

endpackage

// File: rtl/sbdma_regs.sv
module sbdma_regs
  import sbdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          step,
  input  logic          done_set,
  output logic [AW-1:0] paddr,
  output logic [AW-1:0] maddr,
  output logic [CW-1:0] count,
  output logic          chan_en,
  output logic          dir,
  output logic          irq_en,
  output logic          prog_ge2,
  output logic          done,
  output logic          irq
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [CW-1:0] CNT_TWO = CW'(2);

  logic wr_paddr, wr_maddr, wr_count, wr_ctrl;
  logic done_n, ien_n;

  assign wr_paddr = cfg_wr && (cfg_addr == RA_PADDR);
  assign wr_maddr = cfg_wr && (cfg_addr == RA_MADDR);
  assign wr_count = cfg_wr && (cfg_addr == RA_COUNT);
  assign wr_ctrl  = cfg_wr && (cfg_addr == RA_CTRL);

  // completion set has priority over a software clear in the same cycle
  assign done_n = done_set | (done & ~(wr_ctrl | wr_count));
  assign ien_n  = wr_ctrl ? cfg_wdata[CB_IEN] : irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      paddr    <= '0;
      maddr    <= '0;
      count    <= '0;
      chan_en  <= 1'b0;
      dir      <= 1'b0;
      irq_en   <= 1'b0;
      prog_ge2 <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_paddr) paddr <= cfg_wdata[AW-1:0];

      if (wr_maddr)  maddr <= cfg_wdata[AW-1:0];
      else if (step) maddr <= maddr + AW'(1);

      if (wr_count) begin
        count    <= cfg_wdata[CW-1:0];
        prog_ge2 <= (cfg_wdata[CW-1:0] >= CNT_TWO);
      end else if (step) begin
        count <= count - CNT_ONE;
      end

      if (wr_ctrl) begin
        chan_en <= cfg_wdata[CB_EN];
        dir     <= cfg_wdata[CB_DIR];
        irq_en  <= cfg_wdata[CB_IEN];
      end

      done <= done_n;
      irq  <= done_n & ien_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RA_PADDR: cfg_rdata <= RW'(paddr);
        RA_MADDR: cfg_rdata <= RW'(maddr);
        RA_COUNT: cfg_rdata <= RW'(count);
        default:  cfg_rdata <= RW'({done, irq_en, dir, chan_en});
      endcase
    end
  end

endmodule

// File: rtl/sbdma_req.sv
module sbdma_req #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          dma_en,
  input  logic          dir,
  input  logic          txe,
  input  logic          rxne,
  input  logic [CW-1:0] count,
  input  logic          busy,
  input  logic          buf_irq_en,
  output logic          req,
  output logic          buf_irq_out
);

  logic flag_sel;

  assign flag_sel = dir ? txe : rxne;
  assign req      = chan_en & dma_en & (count != '0) & ~busy & flag_sel;

  always_ff @(posedge clk) begin
    if (rst) buf_irq_out <= 1'b0;
    else     buf_irq_out <= buf_irq_en & ~dma_en;
  end

endmodule

// File: rtl/sbdma_engine.sv
module sbdma_engine
  import sbdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          dir,
  input  logic [AW-1:0] maddr,
  input  logic [CW-1:0] count,
  input  logic          eod_en,
  input  logic          prog_ge2,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dr_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          dr_wr,
  output logic          dr_rd,
  output logic [DW-1:0] dr_wdata,
  output logic          step,
  output logic          done_set,
  output logic          busy,
  output logic          xfer_dir,
  output logic          auto_nack
);

  xfer_state_t state;
  logic        last;

  assign step     = (state == ST_COMMIT);
  assign last     = (count == CW'(1));
  assign done_set = step & last;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      dr_wr     <= 1'b0;
      dr_rd     <= 1'b0;
      dr_wdata  <= '0;
      xfer_dir  <= 1'b0;
      auto_nack <= 1'b0;
    end else begin
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      dr_wr     <= 1'b0;
      dr_rd     <= 1'b0;
      auto_nack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            xfer_dir <= dir;
            mem_addr <= maddr;
            if (dir) begin
              mem_re <= 1'b1;
              state  <= ST_TX_RD;
            end else begin
              dr_rd <= 1'b1;
              state <= ST_RX_RD;
            end
          end
        end
        ST_TX_RD:   state <= ST_TX_WAIT;
        ST_TX_WAIT: begin
          dr_wdata <= mem_rdata;
          dr_wr    <= 1'b1;
          state    <= ST_COMMIT;
        end
        ST_RX_RD: begin
          mem_wdata <= dr_rdata;
          mem_we    <= 1'b1;
          state     <= ST_COMMIT;
        end
        ST_COMMIT: begin
          auto_nack <= last & ~xfer_dir & eod_en & prog_ge2;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbus_dma_chan.sv
module sbus_dma_chan #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          dma_en,
  input  logic          eod_en,
  input  logic          txe,
  input  logic          rxne,
  input  logic          buf_irq_en,
  output logic          buf_irq_out,
  output logic [AW-1:0] per_addr,
  output logic          dr_wr,
  output logic [DW-1:0] dr_wdata,
  output logic          dr_rd,
  input  logic [DW-1:0] dr_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] remain_cnt,
  output logic          irq,
  output logic          auto_nack
);

  logic [AW-1:0] maddr;
  logic [CW-1:0] count;
  logic chan_en, dir, irq_en, prog_ge2, done;
  logic step, done_set, busy, req, xfer_dir;

  sbdma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .step(step), .done_set(done_set),
    .paddr(per_addr), .maddr(maddr), .count(count),
    .chan_en(chan_en), .dir(dir), .irq_en(irq_en),
    .prog_ge2(prog_ge2), .done(done), .irq(irq)
  );

  sbdma_req #(.CW(CW)) u_req (
    .clk(clk), .rst(rst),
    .chan_en(chan_en), .dma_en(dma_en), .dir(dir),
    .txe(txe), .rxne(rxne), .count(count), .busy(busy),
    .buf_irq_en(buf_irq_en), .req(req), .buf_irq_out(buf_irq_out)
  );

  sbdma_engine #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst),
    .req(req), .dir(dir), .maddr(maddr), .count(count),
    .eod_en(eod_en), .prog_ge2(prog_ge2),
    .mem_rdata(mem_rdata), .dr_rdata(dr_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .dr_wr(dr_wr), .dr_rd(dr_rd),
    .dr_wdata(dr_wdata), .step(step), .done_set(done_set),
    .busy(busy), .xfer_dir(xfer_dir), .auto_nack(auto_nack)
  );

  assign remain_cnt = count;

endmodule

// File: rtl/sbus_dma_chan_chk.sv
module sbus_dma_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic [1:0]    cfg_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic          dr_wr,
  input logic          dr_rd,
  input logic          step,
  input logic          busy,
  input logic          xfer_dir,
  input logic [CW-1:0] remain_cnt,
  input logic          irq,
  input logic          auto_nack
);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_re, mem_we, dr_wr, dr_rd}));

  // R1
  tx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (dr_wr || mem_re) |-> xfer_dir);

  // R1
  rx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (dr_rd || mem_we) |-> !xfer_dir);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !(cfg_wr && cfg_addr == 2'd2)) |=> (remain_cnt == $past(remain_cnt) - CW'(1)));

  // R3
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (remain_cnt == '0 && !busy) |=> (!mem_re && !dr_rd));

  // R5
  irq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (remain_cnt == '0));

  // R8
  nack_rx_chk: assert property (@(posedge clk) disable iff (rst)
    auto_nack |-> (remain_cnt == '0 && !xfer_dir));

  // R8
  nack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    auto_nack |=> !auto_nack);

endmodule

bind sbus_dma_chan sbus_dma_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .mem_re(mem_re), .mem_we(mem_we), .dr_wr(dr_wr), .dr_rd(dr_rd),
  .step(step), .busy(busy), .xfer_dir(xfer_dir),
  .remain_cnt(remain_cnt), .irq(irq), .auto_nack(auto_nack)
);

// File: tb/sbus_dma_chan_tb.sv
`timescale 1ns/1ps
module sbus_dma_chan_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        dma_en = 1'b0, eod_en = 1'b0, buf_irq_en = 1'b0;
  logic        txe, rxne, buf_irq_out;
  logic [15:0] per_addr, mem_addr, remain_cnt;
  logic        dr_wr, dr_rd, mem_re, mem_we, irq, auto_nack;
  logic [7:0]  dr_wdata, mem_wdata, mem_rdata, rx_q;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sbus_dma_chan u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_en(dma_en),
    .eod_en(eod_en), .txe(txe), .rxne(rxne), .buf_irq_en(buf_irq_en),
    .buf_irq_out(buf_irq_out), .per_addr(per_addr), .dr_wr(dr_wr),
    .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(rx_q),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .remain_cnt(remain_cnt),
    .irq(irq), .auto_nack(auto_nack)
  );

  // memory model: registered read, preset pattern (a*7+3)
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      mem_rdata <= '0;
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // bus controller model
  logic       clr = 1'b1, tx_act = 1'b0, rx_act = 1'b0;
  logic [7:0] rx_seed = '0;
  logic [7:0] tx_log [16];
  int tx_n, rx_sent, refill, gap, nack_n;
  always @(posedge clk) begin
    if (clr) begin
      tx_n <= 0; rx_sent <= 0; refill <= 0; gap <= 0; nack_n <= 0;
      txe <= 1'b0; rxne <= 1'b0; rx_q <= '0;
    end else begin
      if (auto_nack) nack_n <= nack_n + 1;
      if (dr_wr) begin
        if (tx_n < 16) tx_log[tx_n] <= dr_wdata;
        tx_n <= tx_n + 1; txe <= 1'b0; refill <= 3;
      end else if (refill > 0) refill <= refill - 1;
      else if (tx_act) txe <= 1'b1;
      if (dr_rd) begin
        rxne <= 1'b0; gap <= 2;
      end else if (gap > 0) gap <= gap - 1;
      else if (rx_act && !rxne) begin
        rxne <= 1'b1; rx_q <= rx_seed + 8'(rx_sent * 5); rx_sent <= rx_sent + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_w(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_r(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic restart(input logic tx, input logic rx, input logic [7:0] seed);
    @(negedge clk); clr = 1'b1; tx_act = tx; rx_act = rx; rx_seed = seed;
    @(negedge clk); clr = 1'b0;
  endtask

  typedef struct packed {
    logic       dir;
    logic       eod;
    logic       ien;
    logic [3:0] cnt;
    logic [7:0] base;
    logic [7:0] seed;
    logic       nack;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b1, 4'd1, 8'h10, 8'h00, 1'b0},
    '{1'b1, 1'b1, 1'b1, 4'd2, 8'h20, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b1, 4'd5, 8'h30, 8'h00, 1'b0},
    '{1'b0, 1'b1, 1'b1, 4'd1, 8'h80, 8'hA1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 4'd2, 8'h90, 8'h42, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'd5, 8'hA0, 8'h17, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'd5, 8'hB0, 8'h66, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd2, 8'hC0, 8'h3C, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    vec_t t;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk({irq, auto_nack, dr_wr, dr_rd, mem_re, mem_we, buf_irq_out} == 7'd0, "R10 strobes", 0, 0);
    chk(remain_cnt == 0 && per_addr == 0, "R10 count/addr", remain_cnt, 0);
    cfg_r(2'd3, rd);
    chk(rd == 0, "R10 ctrl read", rd, 0);

    for (int v = 0; v < 8; v++) begin
      t = VEC[v];
      restart(t.dir, !t.dir, t.seed);
      eod_en = t.eod;
      cfg_w(2'd0, 16'h0040);
      cfg_w(2'd1, {8'h00, t.base});
      cfg_w(2'd2, {12'h000, t.cnt});
      dma_en = 1'b1;
      cfg_w(2'd3, {13'd0, t.ien, t.dir, 1'b1});
      for (int k = 0; k < 500 && remain_cnt != 0; k++) @(negedge clk);
      chk(remain_cnt == 0, "R3 final count", remain_cnt, 0);
      chk(irq == t.ien, "R5 irq with zero count", irq, t.ien);
      chk(auto_nack == t.nack, "R8 nack cycle", auto_nack, t.nack);
      repeat (8) @(negedge clk);
      chk(irq == t.ien, "R5 irq held", irq, t.ien);
      chk(nack_n == int'(t.nack), "R8 nack pulses", nack_n, t.nack);
      ok = 1'b1;
      if (t.dir) begin
        chk(tx_n == int'(t.cnt), "R2 R7 tx byte count", tx_n, t.cnt);
        for (int i = 0; i < int'(t.cnt); i++)
          if (tx_log[i] != 8'((int'(t.base) + i) * 7 + 3)) ok = 1'b0;
        chk(ok, "R1 tx byte order", v, v);
      end else begin
        for (int i = 0; i < int'(t.cnt); i++)
          if (mem[t.base + 8'(i)] != t.seed + 8'(i * 5)) ok = 1'b0;
        chk(ok, "R1 rx byte order", v, v);
      end
      cfg_r(2'd1, rd);
      chk(rd == 16'(t.base) + 16'(t.cnt), "R4 memory address", rd, t.base + t.cnt);
      chk(per_addr == 16'h0040, "R4 peripheral address", per_addr, 16'h40);
      dma_en = 1'b0;
      cfg_w(2'd3, 16'h0000);
      chk(irq == 1'b0, "R5 cleared by ctrl write", irq, 0);
    end

    // R6: DMA-enable gate, then channel-enable clear mid-run
    restart(1'b1, 1'b0, 8'h00);
    cfg_w(2'd1, 16'h0050);
    cfg_w(2'd2, 16'd3);
    cfg_w(2'd3, 16'h0003);
    repeat (20) @(negedge clk);
    chk(tx_n == 0 && remain_cnt == 3, "R6 no move without dma_en", tx_n, 0);
    dma_en = 1'b1;
    for (int k = 0; k < 200 && tx_n < 2; k++) @(negedge clk);
    cfg_w(2'd3, 16'h0002);
    repeat (20) @(negedge clk);
    chk(tx_n == 2, "R6 stop after enable clear", tx_n, 2);
    cfg_r(2'd2, rd);
    chk(rd == 16'd1, "R6 remaining count readable", rd, 1);
    cfg_r(2'd1, rd);
    chk(rd == 16'h0052, "R4 R6 address frozen", rd, 16'h52);
    chk(irq == 1'b0, "R5 no irq when stopped", irq, 0);

    // R5: final commit and control write in the same cycle
    restart(1'b1, 1'b0, 8'h00);
    cfg_w(2'd1, 16'h0060);
    cfg_w(2'd2, 16'd1);
    cfg_w(2'd3, 16'h0007);
    for (int k = 0; k < 200 && !dr_wr; k++) @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h0004;
    @(negedge clk); cfg_wr = 1'b0;
    chk(irq == 1'b1 && remain_cnt == 0, "R5 set wins over clear", irq, 1);
    chk(tx_n == 1, "R2 single byte", tx_n, 1);
    cfg_r(2'd3, rd);
    chk(rd == 16'h000C, "R5 done bit read", rd, 16'hC);
    cfg_w(2'd3, 16'h0000);
    chk(irq == 1'b0, "R5 later clear", irq, 0);
    dma_en = 1'b0;

    // R9: data-buffer interrupt mask
    buf_irq_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(buf_irq_out == 1'b1, "R9 pass when dma off", buf_irq_out, 1);
    dma_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(buf_irq_out == 1'b0, "R9 masked when dma on", buf_irq_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule